// File: doc/BRIEF.md
# Open-Row DRAM Controller

This block connects a plain request port (valid/ready, read or write, word address, write data) to a behaviourally modelled DRAM array. The array is a grid of rows and columns of multi-bit supercells. Its address pins are only as wide as the larger of the row and column indices. The controller therefore splits each word address into a row index (upper bits) and a column index (lower bits). It drives them one after the other on the shared pins, first under a row strobe and then under a column strobe.

A row strobe copies a whole row of the array into an internal row buffer. A column strobe then reads one supercell from that buffer onto the data lines, or overwrites it. The controller remembers which row is open. A request to the open row skips straight to the column phase. A request to another row first writes the buffer back into the array under a write-back strobe, with the old row index on the pins, and then opens the new row. Writes change only the buffer, and reach the array when their row is closed. Each strobe phase lasts `PHASE_CYC` clock cycles.

Top module: `dram_rb_ctrl`

## Requirements
- R1: While reset is held, `req_ready_o` is 1 and `rsp_valid_o`, `dram_ras_o`, `dram_cas_o` and `dram_wb_o` are 0; no row is open after reset.
- R2: The first request after reset drives one row phase and then one column phase, with no write-back phase.
- R3: The word address is split as row = `req_addr_i[ADDR_W-1:COL_W]` and column = `req_addr_i[COL_W-1:0]`. `dram_addr_o` carries the row index during the row and write-back phases and the column index during the column phase.
- R4: A request whose row equals the open row drives only a column phase.
- R5: A request to a row other than the open one drives a write-back phase carrying the old row index, then a row phase, then a column phase, in that order.
- R6: A read completes with `rsp_valid_o` high for exactly one cycle, in the first cycle after its column phase. `rsp_rdata_o` then holds the last value written to that address. A write produces no `rsp_valid_o` pulse.
- R7: Written data is visible to later reads while its row stays open, and still after the row has been closed and opened again.
- R8: Every strobe phase lasts exactly `PHASE_CYC` cycles, and at most one of the three strobes is high in any cycle.
- R9: `req_ready_o` is low from the cycle after a request is accepted until its column phase completes. A request held on the port during that time is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle; request taken at this edge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address {row, column} |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| dram_ras_o | output | 1 | Row strobe to the array |
| dram_cas_o | output | 1 | Column strobe to the array |
| dram_wb_o | output | 1 | Row write-back strobe to the array |
| dram_addr_o | output | BUS_W | Multiplexed row/column index pins |

## Verification
The hardest case to reach is a write that sits only in the row buffer while its row is closed and later reopened. This is the only path that exercises the write-back into the array. The stimulus first fills every address with known data. Directed sequences then write, switch rows and read back. Random traffic with addresses drawn mostly from two rows produces long runs of hits broken by row conflicts. A reference model of the memory and of the open row predicts the strobe order, the pin values and the returned data.

// File: rtl/dram_rb_pkg.sv
package dram_rb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_ROW  = 2'd2,
    ST_COL  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dram_rb_seq.sv
module dram_rb_seq
  import dram_rb_pkg::*;
#(
  parameter int ROW_W     = 2,
  parameter int COL_W     = 2,
  parameter int BUS_W     = 2,
  parameter int PHASE_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  output logic             ready_o,
  output logic             ras_o,
  output logic             cas_o,
  output logic             wb_o,
  output logic [BUS_W-1:0] bus_o,
  output logic             done_o
);
  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             open_vld_q;
  logic [ROW_W-1:0] open_row_q, cur_row_q;
  logic [COL_W-1:0] cur_col_q;
  logic             phase_last;

  assign phase_last = (cnt_q == CNT_W'(PHASE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      open_vld_q <= 1'b0;
      open_row_q <= '0;
      cur_row_q  <= '0;
      cur_col_q  <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cur_row_q <= req_row_i;
          cur_col_q <= req_col_i;
          cnt_q     <= '0;
          if (open_vld_q && open_row_q == req_row_i) state_q <= ST_COL;
          else if (open_vld_q)                        state_q <= ST_WB;
          else                                        state_q <= ST_ROW;
        end
        ST_WB: if (phase_last) begin
          cnt_q      <= '0;
          open_vld_q <= 1'b0;
          state_q    <= ST_ROW;
        end else cnt_q <= cnt_q + 1'b1;
        ST_ROW: if (phase_last) begin
          cnt_q      <= '0;
          open_vld_q <= 1'b1;
          open_row_q <= cur_row_q;
          state_q    <= ST_COL;
        end else cnt_q <= cnt_q + 1'b1;
        ST_COL: if (phase_last) begin
          cnt_q   <= '0;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign wb_o    = (state_q == ST_WB);
  assign ras_o   = (state_q == ST_ROW);
  assign cas_o   = (state_q == ST_COL);

  always_comb begin
    unique case (state_q)
      ST_WB:   bus_o = BUS_W'(open_row_q);
      ST_ROW:  bus_o = BUS_W'(cur_row_q);
      ST_COL:  bus_o = BUS_W'(cur_col_q);
      default: bus_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_rb_array.sv
module dram_rb_array #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 2
) (
  input  logic              clk_i,
  input  logic              ras_i,
  input  logic              cas_i,
  input  logic              wb_i,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic [COLS-1:0][DATA_W-1:0] cells [ROWS];
  logic [COLS-1:0][DATA_W-1:0] row_buf;
  logic [ROW_W-1:0]            row_idx;
  logic [COL_W-1:0]            col_idx;

  assign row_idx = addr_i[ROW_W-1:0];
  assign col_idx = addr_i[COL_W-1:0];

  // Array contents are deliberately not reset.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (wb_i && row_idx == ROW_W'(r)) cells[r] <= row_buf;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ras_i) row_buf <= cells[row_idx];
    else if (cas_i && we_i) row_buf[col_idx] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (cas_i && !we_i) rdata_o <= row_buf[col_idx];
  end
endmodule

// File: rtl/dram_rb_ctrl.sv
module dram_rb_ctrl #(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int DATA_W    = 8,
  parameter int PHASE_CYC = 1,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int COL_W    = $clog2(COLS),
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              dram_ras_o,
  output logic              dram_cas_o,
  output logic              dram_wb_o,
  output logic [BUS_W-1:0]  dram_addr_o
);
  logic              accept, done;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= req_we_i;
      wdata_q <= req_wdata_i;
    end
  end

  dram_rb_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W), .PHASE_CYC(PHASE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_row_i   (req_addr_i[ADDR_W-1:COL_W]),
    .req_col_i   (req_addr_i[COL_W-1:0]),
    .ready_o     (req_ready_o),
    .ras_o       (dram_ras_o),
    .cas_o       (dram_cas_o),
    .wb_o        (dram_wb_o),
    .bus_o       (dram_addr_o),
    .done_o      (done)
  );

  dram_rb_array #(
    .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .BUS_W(BUS_W)
  ) u_array (
    .clk_i   (clk_i),
    .ras_i   (dram_ras_o),
    .cas_i   (dram_cas_o),
    .wb_i    (dram_wb_o),
    .addr_i  (dram_addr_o),
    .we_i    (we_q),
    .wdata_i (wdata_q),
    .rdata_o (rsp_rdata_o)
  );

  assign rsp_valid_o = done && !we_q;
endmodule

// File: rtl/dram_rb_ctrl_chk.sv
module dram_rb_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic dram_ras_o,
  input logic dram_cas_o,
  input logic dram_wb_o
);
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_ras_o, dram_cas_o, dram_wb_o}));

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_ras_o || dram_cas_o || dram_wb_o) |-> !req_ready_o);

  assert_rsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_after_col_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(dram_cas_o));

  assert_wb_then_row_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_wb_o) |-> dram_ras_o);

  assert_row_then_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_o) |-> dram_cas_o);
endmodule

bind dram_rb_ctrl dram_rb_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .dram_ras_o  (dram_ras_o),
  .dram_cas_o  (dram_cas_o),
  .dram_wb_o   (dram_wb_o)
);

// File: tb/dram_rb_ctrl_bench.sv
module dram_rb_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 4, DATA_W = 8, PHASE_CYC = 1;
  localparam int ROW_W = $clog2(ROWS), COL_W = $clog2(COLS);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NWORDS = ROWS * COLS;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras, cas, wb;
  logic [DATA_W-1:0] rsp_rdata;
  logic [BUS_W-1:0] dram_addr;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] ref_mem [NWORDS];
  logic open_vld = 1'b0;
  logic [ROW_W-1:0] open_row = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rb_ctrl #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .PHASE_CYC(PHASE_CYC)) u_dram_rb_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .dram_ras_o(ras),
    .dram_cas_o(cas), .dram_wb_o(wb), .dram_addr_o(dram_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_phase_cnt(input bit is_hit, input bit had_open, input int which);
    // which: 0 = write-back, 1 = row, 2 = column
    if (which == 2) return PHASE_CYC;
    if (is_hit) return 0;
    if (which == 1) return PHASE_CYC;
    return had_open ? PHASE_CYC : 0;
  endfunction

  // One request; hold keeps valid high with other fields while busy (R9).
  task automatic do_req(input bit we, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] data, input bit hold);
    int n_wb = 0, n_ras = 0, n_cas = 0, cyc = 0;
    int t_wb = -1, t_ras = -1, t_cas = -1;
    bit bus_ok = 1'b1;
    bit is_hit, had_open;
    logic [ROW_W-1:0] row, old_row;
    logic [COL_W-1:0] col;
    row = addr[ADDR_W-1:COL_W];
    col = addr[COL_W-1:0];
    is_hit = open_vld && open_row == row;
    had_open = open_vld;
    old_row = open_row;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      req_we = ~we; req_addr = ~addr; req_wdata = ~data;
    end else req_valid = 1'b0;
    while (!req_ready && cyc < 200) begin
      if (wb)  begin n_wb++;  if (t_wb < 0)  t_wb = cyc;  if (dram_addr != BUS_W'(old_row)) bus_ok = 1'b0; end
      if (ras) begin n_ras++; if (t_ras < 0) t_ras = cyc; if (dram_addr != BUS_W'(row)) bus_ok = 1'b0; end
      if (cas) begin n_cas++; if (t_cas < 0) t_cas = cyc; if (dram_addr != BUS_W'(col)) bus_ok = 1'b0; end
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(cyc < 200, "R9 completion", cyc, 0);
    chk(bus_ok, "R3 address pins carry row/column", bus_ok, 1);
    chk(n_cas == exp_phase_cnt(is_hit, had_open, 2), "R8 column phase length", n_cas, PHASE_CYC);
    chk(n_ras == exp_phase_cnt(is_hit, had_open, 1),
        is_hit ? "R4 no row phase on hit" : (had_open ? "R5 row phase" : "R2 row phase"),
        n_ras, exp_phase_cnt(is_hit, had_open, 1));
    chk(n_wb == exp_phase_cnt(is_hit, had_open, 0),
        had_open ? "R5 write-back phase" : "R2 no write-back", n_wb, exp_phase_cnt(is_hit, had_open, 0));
    chk(cyc == n_wb + n_ras + n_cas, "R9 ready low only while busy", cyc, n_wb + n_ras + n_cas);
    if (!is_hit) chk(t_ras < t_cas && (!had_open || t_wb < t_ras), "R5 phase order",
                     t_ras, t_cas);
    if (we) begin
      chk(rsp_valid == 1'b0, "R6 no pulse on write", rsp_valid, 0);
      ref_mem[addr] = data;
    end else begin
      chk(rsp_valid == 1'b1, "R6 read pulse", rsp_valid, 1);
      chk(rsp_rdata == ref_mem[addr], "R7 read data", rsp_rdata, ref_mem[addr]);
    end
    open_vld = 1'b1; open_row = row;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6 pulse is one cycle", rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #(CLK_PERIOD * 2 + 3);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp in reset", rsp_valid, 0);
    chk({ras, cas, wb} == 3'b000, "R1 strobes in reset", {ras, cas, wb}, 0);
    rst_ni = 1'b1;

    // R2 cold access, then fill every word
    do_req(1'b1, ADDR_W'(6), 8'hA6, 1'b0);
    for (int a = 0; a < NWORDS; a++) do_req(1'b1, ADDR_W'(a), DATA_W'(a * 37 + 5), 1'b0);
    // R4 hits on open row, R7 read-after-write in open row
    do_req(1'b1, ADDR_W'(NWORDS - 2), 8'h3C, 1'b0);
    do_req(1'b0, ADDR_W'(NWORDS - 2), 8'h00, 1'b0);
    do_req(1'b0, ADDR_W'(NWORDS - 1), 8'h00, 1'b0);
    // R5/R7 write, close row, reopen
    do_req(1'b1, ADDR_W'(1), 8'h5A, 1'b0);
    do_req(1'b0, ADDR_W'(COLS + 1), 8'h00, 1'b0);
    do_req(1'b0, ADDR_W'(1), 8'h00, 1'b0);
    // R9 request held while busy has no effect
    do_req(1'b0, ADDR_W'(2 * COLS), 8'h00, 1'b1);
    do_req(1'b1, ADDR_W'(3), 8'hC3, 1'b1);
    do_req(1'b0, ADDR_W'(3), 8'h00, 1'b0);
    do_req(1'b0, ~ADDR_W'(3), 8'h00, 1'b0);

    // R1 reset closes the row: next access must not write back
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    open_vld = 1'b0;
    do_req(1'b0, ADDR_W'(5), 8'h00, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [ROW_W-1:0] r;
      logic [ADDR_W-1:0] a;
      r = ($urandom % 4 == 0) ? ROW_W'($urandom) : ROW_W'($urandom % 2);
      a = {r, COL_W'($urandom)};
      do_req(1'($urandom), a, DATA_W'($urandom), ($urandom % 8 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule